// File: doc/BRIEF.md
# Programmable SCL Clock Generator

This block produces the serial clock for a two-wire bus controller acting as the bus master. A bit engine asks for clock periods by holding `clk_en` high; the generator answers with an open-drain pull on the clock line, plus two one-cycle strobes. One strobe tells the bit engine when to move SDA. The other tells it when to sample SDA. Each SCL period is built from a programmed high count and a programmed low count. Two count pairs are stored, one for standard speed and one for fast speed, and `mode_fast` picks the pair when a sequence starts.

The generator adds fixed overhead cycles to the programmed counts. The low phase starts counting in the cycle the pull is applied, whatever the line is doing. The high phase counts only cycles in which `scl_sense` reads high. A target that holds the line low therefore stretches the period. Before the first low phase there is a start-hold interval with SCL released, during which the bit engine holds the start condition on SDA. Count registers can only be written while `enable` is low, and values below a floor are raised to that floor.

The controller runs the states Idle, Hold, Low and High:
- Idle to Hold happens when `enable` and `clk_en` are both high.
- Hold to Low happens when the start-hold count expires.
- Low to High happens when the low count expires.
- High to Low happens when the high count expires and `clk_en` is high.
- High to Idle happens when the high count expires and `clk_en` is low.
- Any state goes to Idle when `enable` is low.

Top module: `scl_gen`

## Requirements
- R1: Each low phase holds `scl_pull_low` high for exactly L+1 clock cycles, where L is the effective low count. The pull is asserted in the first cycle of the phase.
- R2: With no stretching, each high phase releases SCL for exactly H+8 clock cycles, where H is the effective high count.
- R3: After `clk_en` is sampled high in Idle, SCL stays released for a start hold of H+3 cycles. The first pull is therefore seen H+4 cycles after the cycle in which `clk_en` was raised.
- R4: `cfg_addr` selects the count register being written: 0 is standard high, 1 is standard low, 2 is fast high, 3 is fast low. `mode_fast`=1 selects the fast pair and 0 selects the standard pair. The pair is captured on the edge that leaves Idle.
- R5: A write (`cfg_we`=1) while `enable`=1 leaves the register unchanged. A write while `enable`=0 takes effect for the next sequence.
- R6: The high-phase counter advances only in cycles where `scl_sense` is high. A target holding SCL low for S released cycles lengthens the high phase to S+H+8 cycles.
- R7: `sda_change_stb` pulses exactly once per low phase, in low-phase cycle index 2, counting from 0.
- R8: `sample_stb` pulses exactly once per high phase, in the counted high cycle with index (H+8)/2 using integer division. It never pulses while SCL is pulled low.
- R9: The effective high count is the larger of the stored value and 6. The effective low count is the larger of the stored value and 8.
- R10: If `clk_en` is low when a high phase ends, SCL stays released and no further low phase follows. If `enable` is driven low, SCL is released from the next cycle.
- R11: After reset, SCL is released and both strobes are low. The count registers hold standard 40/47 and fast 6/13 (high/low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; blocks count writes and forces Idle when low |
| clk_en | input | 1 | Request for clock periods from the bit engine |
| mode_fast | input | 1 | 1 selects the fast count pair, 0 the standard pair |
| cfg_we | input | 1 | Count register write strobe |
| cfg_addr | input | 2 | Count register select (see R4) |
| cfg_wdata | input | 16 | Count value to write |
| scl_sense | input | 1 | Sensed level of the SCL line |
| scl_pull_low | output | 1 | Open-drain drive: 1 pulls SCL low |
| sda_change_stb | output | 1 | One-cycle strobe marking when SDA may change |
| sample_stb | output | 1 | One-cycle strobe marking when SDA is sampled |

## Verification
The assertions assume that `scl_sense` is synchronous to `clk` and reads low in every cycle the block pulls the line. A high reading is only possible while the pull is released. They also assume that `enable` is the only cause of an abrupt return to Idle. The bench models the line as the wired-AND of the pull and a target stretch flag, so `scl_sense` can never be high while the pull is asserted. The stretch flag is raised only during a low phase and is dropped after a chosen number of released cycles. Count values, stretch lengths and speed modes are drawn randomly with a fixed seed. Registers are written only while `enable` is low, except in the one directed case that checks writes are ignored.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_LOW,
        ST_HIGH
    } scl_state_e;

    typedef enum logic [1:0] {
        CFG_STD_HI  = 2'd0,
        CFG_STD_LO  = 2'd1,
        CFG_FAST_HI = 2'd2,
        CFG_FAST_LO = 2'd3
    } cfg_addr_e;

    // extra reference cycles added to the programmed counts
    localparam int unsigned HI_OVERHEAD = 8;  // 1 + 4 + 3
    localparam int unsigned START_EXTRA = 3;

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
    import scl_gen_pkg::*;
#(
    parameter int unsigned CW          = 16,
    parameter int unsigned MIN_HI      = 6,
    parameter int unsigned MIN_LO      = 8,
    parameter int unsigned RST_STD_HI  = 40,
    parameter int unsigned RST_STD_LO  = 47,
    parameter int unsigned RST_FAST_HI = 6,
    parameter int unsigned RST_FAST_LO = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic          we_i,
    input  logic [1:0]    addr_i,
    input  logic [CW-1:0] wdata_i,
    input  logic          mode_fast_i,
    output logic [CW-1:0] hi_eff_o,
    output logic [CW-1:0] lo_eff_o
);

    localparam int unsigned NREG = 4;
    localparam logic [NREG*CW-1:0] RST_PACK = {
        CW'(RST_FAST_LO), CW'(RST_FAST_HI), CW'(RST_STD_LO), CW'(RST_STD_HI)
    };

    logic [CW-1:0] cnt_reg [NREG];
    logic [CW-1:0] hi_raw;
    logic [CW-1:0] lo_raw;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_reg[i] <= RST_PACK[i*CW +: CW];
            end else if (we_i && !enable_i && addr_i == 2'(i)) begin
                cnt_reg[i] <= wdata_i;
            end
        end

        AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            enable_i |=> $stable(cnt_reg[i])) else $error("cfg changed while enabled"); // R5
    end

    always_comb begin
        hi_raw   = mode_fast_i ? cnt_reg[CFG_FAST_HI] : cnt_reg[CFG_STD_HI];
        lo_raw   = mode_fast_i ? cnt_reg[CFG_FAST_LO] : cnt_reg[CFG_STD_LO];
        hi_eff_o = (hi_raw < CW'(MIN_HI)) ? CW'(MIN_HI) : hi_raw;
        lo_eff_o = (lo_raw < CW'(MIN_LO)) ? CW'(MIN_LO) : lo_raw;
    end

endmodule

// File: rtl/scl_fsm.sv
module scl_fsm
    import scl_gen_pkg::*;
#(
    parameter int unsigned CW      = 16,
    parameter int unsigned SDA_DLY = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic          run_i,
    input  logic          scl_in_i,
    input  logic [CW-1:0] hi_eff_i,
    input  logic [CW-1:0] lo_eff_i,
    output logic          scl_pull_o,
    output logic          sda_chg_o,
    output logic          sample_o
);

    localparam int unsigned CNT_W = CW + 1;

    scl_state_e        state_q, state_n;
    logic [CNT_W-1:0]  cnt_q;
    logic [CW-1:0]     hi_q, lo_q;
    logic [CNT_W-1:0]  hold_end, low_end, high_end, high_mid;

    assign hold_end = {1'b0, hi_q} + CNT_W'(START_EXTRA - 1);
    assign low_end  = {1'b0, lo_q};
    assign high_end = {1'b0, hi_q} + CNT_W'(HI_OVERHEAD - 1);
    assign high_mid = ({1'b0, hi_q} + CNT_W'(HI_OVERHEAD)) >> 1;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (run_i) state_n = ST_HOLD;
            ST_HOLD: if (cnt_q == hold_end) state_n = ST_LOW;
            ST_LOW:  if (cnt_q == low_end) state_n = ST_HIGH;
            ST_HIGH: if (scl_in_i && cnt_q == high_end)
                         state_n = run_i ? ST_LOW : ST_IDLE;
        endcase
        if (!enable_i) state_n = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else begin
            if (state_q == ST_IDLE) begin
                hi_q <= hi_eff_i;
                lo_q <= lo_eff_i;
            end
            if (state_n != state_q || state_q == ST_IDLE)
                cnt_q <= '0;
            else if (state_q != ST_HIGH || scl_in_i)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        scl_pull_o = (state_q == ST_LOW);
        sda_chg_o  = (state_q == ST_LOW) && (cnt_q == CNT_W'(SDA_DLY));
        sample_o   = (state_q == ST_HIGH) && scl_in_i && (cnt_q == high_mid);
    end

    AST_LOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LOW && cnt_q != low_end && enable_i |=> state_q == ST_LOW)
        else $error("low phase cut short"); // R1
    AST_STRETCH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HIGH && !scl_in_i && enable_i |=> state_q == ST_HIGH && $stable(cnt_q))
        else $error("high count moved while line low"); // R6
    AST_SAMPLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> !sample_o) else $error("double sample strobe"); // R8
    AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull_o |-> !sample_o) else $error("sample while pulled"); // R8
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> state_q == ST_IDLE && !scl_pull_o) else $error("not idle"); // R10

endmodule

// File: rtl/scl_gen.sv
module scl_gen
    import scl_gen_pkg::*;
#(
    parameter int unsigned CW      = 16,
    parameter int unsigned MIN_HI  = 6,
    parameter int unsigned MIN_LO  = 8,
    parameter int unsigned SDA_DLY = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          clk_en,
    input  logic          mode_fast,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [CW-1:0] cfg_wdata,
    input  logic          scl_sense,
    output logic          scl_pull_low,
    output logic          sda_change_stb,
    output logic          sample_stb
);

    logic [CW-1:0] hi_eff, lo_eff;

    scl_cfg_regs #(
        .CW(CW), .MIN_HI(MIN_HI), .MIN_LO(MIN_LO)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .enable_i(enable),
        .we_i(cfg_we), .addr_i(cfg_addr), .wdata_i(cfg_wdata),
        .mode_fast_i(mode_fast), .hi_eff_o(hi_eff), .lo_eff_o(lo_eff)
    );

    scl_fsm #(
        .CW(CW), .SDA_DLY(SDA_DLY)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .run_i(enable && clk_en),
        .scl_in_i(scl_sense), .hi_eff_i(hi_eff), .lo_eff_i(lo_eff),
        .scl_pull_o(scl_pull_low), .sda_chg_o(sda_change_stb), .sample_o(sample_stb)
    );

endmodule

// File: tb/scl_gen_tb_top.sv
module scl_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, clk_en = 1'b0, mode_fast = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        stretch = 1'b0;
    logic        scl_sense;
    logic        scl_pull_low, sda_change_stb, sample_stb;
    int          total = 0, bad = 0;
    bit          done = 0;

    always #4 clk = ~clk;
    assign scl_sense = !(scl_pull_low || stretch);

    scl_gen dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clk_en(clk_en),
        .mode_fast(mode_fast), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .scl_sense(scl_sense), .scl_pull_low(scl_pull_low),
        .sda_change_stb(sda_change_stb), .sample_stb(sample_stb)
    );

    function automatic int eff(int v, int mn);
        return (v < mn) ? mn : v;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(int addr, int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'(addr); cfg_wdata = 16'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // hi/lo are effective counts; s = stretch cycles per high phase
    task automatic run_seq(int hi, int lo, int s, int nbits);
        int n, r, sda_at, sda_cnt, samp_at, samp_cnt;
        @(negedge clk);
        clk_en = 1'b1;
        n = 0;
        do begin @(negedge clk); #1; n++; end while (!scl_pull_low && n < 2000);
        check(n == hi + 4, "R3 start hold", n, hi + 4);
        for (int b = 0; b < nbits; b++) begin
            bit last = (b == nbits - 1);
            stretch = (s > 0);
            r = 0; sda_at = -1; sda_cnt = 0;
            while (scl_pull_low && r < 2000) begin
                if (sda_change_stb) begin sda_cnt++; if (sda_at < 0) sda_at = r; end
                r++;
                @(negedge clk); #1;
            end
            check(r == lo + 1, "R1 low width", r, lo + 1);
            check(sda_at == 2 && sda_cnt == 1, "R7 sda strobe index", sda_at, 2);
            if (last) clk_en = 1'b0;
            r = 0; samp_at = -1; samp_cnt = 0;
            forever begin
                if (scl_pull_low) break;
                if (sample_stb) begin samp_cnt++; if (samp_at < 0) samp_at = r; end
                r++;
                if (r > s + hi + 20) break;
                @(negedge clk);
                if (r == s) stretch = 1'b0;
                #1;
            end
            check(samp_at == s + (hi + 8) / 2 && samp_cnt == 1, "R8 sample index",
                  samp_at, s + (hi + 8) / 2);
            if (last)
                check(!scl_pull_low, "R10 stop after clk_en low", r, s + hi + 21);
            else
                check(r == s + hi + 8, "R2 R6 high width", r, s + hi + 8);
        end
        stretch = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        check(!scl_pull_low && !sda_change_stb && !sample_stb, "R11 reset outputs",
              {scl_pull_low, sda_change_stb, sample_stb}, 0);
        enable = 1'b1;
        run_seq(40, 47, 0, 2);                 // R11 default standard pair
        mode_fast = 1'b1;
        run_seq(6, 13, 0, 2);                  // R11 default fast pair, R4
        // R9 clamp
        enable = 1'b0; mode_fast = 1'b0;
        cfg_write(0, 2); cfg_write(1, 3);
        enable = 1'b1;
        run_seq(6, 8, 0, 2);
        // R5 writes ignored while enabled
        cfg_write(1, 30); cfg_write(0, 25);
        run_seq(6, 8, 1, 2);
        // R4 fast pair with stretching (R6)
        enable = 1'b0;
        cfg_write(2, 10); cfg_write(3, 12);
        mode_fast = 1'b1; enable = 1'b1;
        run_seq(10, 12, 3, 3);
        // R10 enable drop mid low phase
        @(negedge clk); clk_en = 1'b1;
        begin
            int n = 0;
            do begin @(negedge clk); #1; n++; end while (!scl_pull_low && n < 200);
        end
        enable = 1'b0; clk_en = 1'b0;
        @(negedge clk); #1;
        check(!scl_pull_low, "R10 release on disable", int'(scl_pull_low), 0);
        repeat (5) @(negedge clk);
        #1;
        check(!scl_pull_low && !sda_change_stb, "R10 stays idle", int'(scl_pull_low), 0);
        // random mix
        for (int it = 0; it < 10; it++) begin
            int sh = $urandom_range(0, 20), sl = $urandom_range(0, 20);
            int fh = $urandom_range(0, 20), fl = $urandom_range(0, 20);
            int s  = $urandom_range(0, 5);
            int nb = $urandom_range(2, 3);
            bit m  = 1'($urandom_range(0, 1));
            enable = 1'b0;
            cfg_write(0, sh); cfg_write(1, sl); cfg_write(2, fh); cfg_write(3, fl);
            mode_fast = m; enable = 1'b1;
            if (m) run_seq(eff(fh, 6), eff(fl, 8), s, nb);
            else   run_seq(eff(sh, 6), eff(sl, 8), s, nb);
        end
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule